// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Recognizer

This block is the receiving front end of a slave on a two-wire serial bus. It samples the clock line (SCL) and the data line (SDA) through synchronizers. It recognises START and STOP conditions and shifts in the first byte after each START. The upper seven bits of that byte are compared with an own address that software programs. An all-zero address is a general call. Either kind of match sets its own status flag and raises the interrupt line. A byte that matches neither leaves both flags clear, and the rest of that transaction is ignored.

Once addressed, the block receives data bytes one at a time. Each byte is 8 SCL clocks with no acknowledge clock. After every completed byte, reception pauses. The CPU releases the next byte by writing any (dummy) value to the data location. A STOP ends the transaction. On a STOP, hardware also clears the read/write bit of the own-address register.

Software reaches the block through a small register port. The port has a write strobe and a 2-bit location. Read data is registered and appears one cycle after the location is presented.

Top module: `twi_slave_addr_rx`

## Requirements
- R1: After reset, irq is 0, and reads of location 0 (own address), location 1 (data) and location 2 (status) all return 0x00.
- R2: A START (SDA falling while SCL is high) sets status bit 2 (busy). It also clears status bit 0 (general call) and status bit 1 (addressed) and sets the bit counter to 0. A STOP (SDA rising while SCL is high) clears busy, both flags, the hold bit and irq.
- R3: Data bits are taken on SCL rising edges, most significant bit first. After 8 such edges the completed byte is readable at location 1.
- R4: When bits 7:1 of the first byte after a START equal bits 7:1 of location 0, status bit 1 becomes 1, status bit 0 stays 0, and irq becomes 1.
- R5: When bits 7:1 of the first byte are all zero, status bit 0 becomes 1, status bit 1 stays 0, and irq becomes 1. This holds even when the own address is also zero.
- R6: When the first byte matches neither case, both flags stay 0 and irq stays 0. Later bytes are ignored until the next START, so location 1 keeps the address byte.
- R7: After each byte completes in an addressed transaction, status bit 3 (hold) is 1. While hold is set, SCL edges change neither location 1 nor the bit counter. A write to location 1 clears hold and irq, and the next byte is then received.
- R8: Each completed data byte of an addressed transaction raises irq again.
- R9: Status bits 6:4 hold the bit counter. This is the number of bits received in the current byte, and it returns to 0 after a START and after each completed byte.
- R10: A STOP clears bit 0 (read/write bit) of location 0 and leaves bits 7:1 unchanged.
- R11: A repeated START in the middle of a byte resets the bit counter and restarts address comparison on the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register location (0 own address, 1 data, 2 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| irq | output | 1 | Interrupt request, set on match or on a data byte |

## Verification
The assertions assume that SDA only changes while SCL is low, except when forming a START or a STOP. They also assume that SCL and SDA never change within the same synchronizer window. Under these conditions, one sampled clock tick can never carry both an SCL rising edge and a start or stop condition.

The bench drives the bus from tasks that space every line change by eight system clocks. Data changes only in the low phase of SCL. Repeated STARTs first raise SDA while SCL is low, and only then raise SCL.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] LOC_OWN  = 2'd0;
  localparam logic [REG_AW-1:0] LOC_DATA = 2'd1;
  localparam logic [REG_AW-1:0] LOC_STAT = 2'd2;

  localparam int ST_GC   = 0;
  localparam int ST_AAS  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_HOLD = 3;
  localparam int ST_CNT  = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_HOLD
  } rx_phase_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
  assign scl_rise  = scl_s && !scl_d;
endmodule

// File: rtl/twi_rx_engine.sv
module twi_rx_engine
  import twi_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          sda_bit,
  input  logic [DW-2:0] own_addr,
  input  logic          release_i,
  output logic [DW-1:0] rx_byte,
  output logic          gc,
  output logic          aas,
  output logic          busy,
  output logic          hold,
  output logic          irq,
  output logic [$clog2(DW)-1:0] bit_cnt
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  rx_phase_e     phase;
  logic [DW-1:0] shreg;
  logic [DW-1:0] shnext;
  logic          taking;

  assign shnext = {shreg[DW-2:0], sda_bit};
  assign taking = scl_rise && (phase == PH_ADDR || phase == PH_DATA);
  assign hold   = (phase == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      gc      <= 1'b0;
      aas     <= 1'b0;
      busy    <= 1'b0;
      irq     <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      gc      <= 1'b0;
      aas     <= 1'b0;
      busy    <= 1'b1;
      irq     <= 1'b0;
    end else if (stop_det) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      gc      <= 1'b0;
      aas     <= 1'b0;
      busy    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (release_i) irq <= 1'b0;
      if (release_i && phase == PH_HOLD) phase <= PH_DATA;
      if (taking) begin
        shreg <= shnext;
        if (bit_cnt == LAST) begin
          bit_cnt <= '0;
          rx_byte <= shnext;
          if (phase == PH_ADDR) begin
            if (shnext[DW-1:1] == '0) begin
              gc    <= 1'b1;
              irq   <= 1'b1;
              phase <= PH_HOLD;
            end else if (shnext[DW-1:1] == own_addr) begin
              aas   <= 1'b1;
              irq   <= 1'b1;
              phase <= PH_HOLD;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            irq   <= 1'b1;
            phase <= PH_HOLD;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twi_slave_addr_rx.sv
module twi_slave_addr_rx
  import twi_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int CW = $clog2(DW);

  logic [1:0]    bus_s;
  logic          start_det, stop_det, scl_rise;
  logic [DW-1:0] own_reg, rx_byte, status;
  logic          gc, aas, busy, hold, release_wr;
  logic [CW-1:0] bit_cnt;

  twi_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(bus_s)
  );

  twi_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise)
  );

  assign release_wr = reg_wr && (reg_addr == LOC_DATA);

  twi_rx_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .sda_bit(bus_s[0]), .own_addr(own_reg[DW-1:1]),
    .release_i(release_wr), .rx_byte(rx_byte), .gc(gc), .aas(aas),
    .busy(busy), .hold(hold), .irq(irq), .bit_cnt(bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_reg <= '0;
    end else if (reg_wr && reg_addr == LOC_OWN) begin
      own_reg <= reg_wdata;
    end else if (stop_det) begin
      own_reg[0] <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[ST_GC]   = gc;
    status[ST_AAS]  = aas;
    status[ST_BUSY] = busy;
    status[ST_HOLD] = hold;
    status[ST_CNT +: CW] = bit_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        LOC_OWN:  reg_rdata <= own_reg;
        LOC_DATA: reg_rdata <= rx_byte;
        LOC_STAT: reg_rdata <= status;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/twi_slave_addr_rx_chk.sv
module twi_slave_addr_rx_chk
  import twi_rx_pkg::*;
#(
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_det,
  input logic              stop_det,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              own_rw,
  input logic              gc,
  input logic              aas,
  input logic              busy,
  input logic              hold,
  input logic              irq,
  input logic [CW-1:0]     bit_cnt
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (busy && !gc && !aas && bit_cnt == '0));

  assert_irq_needs_match_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (gc || aas));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(gc && aas));

  assert_irq_rise_holds_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> hold);

  assert_hold_cnt_zero_R9: assert property (@(posedge clk) disable iff (rst)
    hold |-> bit_cnt == '0);

  assert_stop_clears_rw_R10: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !(reg_wr && reg_addr == LOC_OWN)) |=> !own_rw);
endmodule

bind twi_slave_addr_rx twi_slave_addr_rx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .own_rw(own_reg[0]),
  .gc(gc), .aas(aas), .busy(busy), .hold(hold), .irq(irq), .bit_cnt(bit_cnt)
);

// File: tb/twi_slave_addr_rx_bench.sv
module twi_slave_addr_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  localparam int Q = 8;

  always #10 clk = ~clk;

  twi_slave_addr_rx u_twi_slave_addr_rx (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    repeat (2) @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; wq();
    scl = 1'b1; wq();
    sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda = 1'b0; wq();
    scl = 1'b1; wq();
    sda = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b);
    sda = b; wq();
    scl = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd0, v); chk("R1 own", v, 8'h00);
    rd(2'd1, v); chk("R1 data", v, 8'h00);
    rd(2'd2, v); chk("R1 status", v, 8'h00);
  endtask

  task automatic t_own_match();
    logic [7:0] v;
    wr(2'd0, 8'hB5);
    bus_start();
    rd(2'd2, v); chk("R2 start status", v, 8'h04);
    bus_byte(8'hB4);
    chk("R4 irq", {7'd0, irq}, 8'h01);
    rd(2'd2, v); chk("R4 status", v, 8'h0E);
    rd(2'd1, v); chk("R3 address byte", v, 8'hB4);
    bus_byte(8'h3C);
    rd(2'd1, v); chk("R7 held data", v, 8'hB4);
    rd(2'd2, v); chk("R7 held status", v, 8'h0E);
    wr(2'd1, 8'h00);
    chk("R7 release irq", {7'd0, irq}, 8'h00);
    rd(2'd2, v); chk("R7 release status", v, 8'h06);
    bus_byte(8'hC3);
    rd(2'd1, v); chk("R3 data byte", v, 8'hC3);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'hFF);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    rd(2'd2, v); chk("R9 count", v, 8'h36);
    bus_stop();
    rd(2'd2, v); chk("R2 stop status", v, 8'h00);
    chk("R2 stop irq", {7'd0, irq}, 8'h00);
    rd(2'd0, v); chk("R10 rw cleared", v, 8'hB4);
  endtask

  task automatic t_gencall();
    logic [7:0] v;
    wr(2'd0, 8'hB4);
    bus_start();
    bus_byte(8'h00);
    chk("R5 irq", {7'd0, irq}, 8'h01);
    rd(2'd2, v); chk("R5 status", v, 8'h0D);
    bus_stop();
    wr(2'd0, 8'h01);
    bus_start();
    bus_byte(8'h01);
    rd(2'd2, v); chk("R5 zero own", v, 8'h0D);
    bus_stop();
    rd(2'd0, v); chk("R10 zero own", v, 8'h00);
  endtask

  task automatic t_nomatch();
    logic [7:0] v;
    wr(2'd0, 8'hB4);
    bus_start();
    bus_byte(8'h66);
    chk("R6 irq", {7'd0, irq}, 8'h00);
    rd(2'd2, v); chk("R6 status", v, 8'h04);
    bus_byte(8'h11);
    rd(2'd1, v); chk("R6 ignored", v, 8'h66);
    chk("R6 irq later", {7'd0, irq}, 8'h00);
    bus_stop();
  endtask

  task automatic t_restart();
    logic [7:0] v;
    wr(2'd0, 8'hB4);
    bus_start();
    bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
    rd(2'd2, v); chk("R9 mid count", v, 8'h44);
    bus_start();
    rd(2'd2, v); chk("R11 restart", v, 8'h04);
    bus_byte(8'hB5);
    rd(2'd2, v); chk("R11 match", v, 8'h0E);
    rd(2'd1, v); chk("R11 byte", v, 8'hB5);
    bus_stop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_own_match();
    t_gencall();
    t_nomatch();
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule